// File: doc/BRIEF.md
# PLL Settings and Clock Switchover Controller

This block is the digital control side of a clock-multiplying PLL. Software stages a multiplier and an output-divider code and then applies them with a commit strobe. The block works out the internal oscillator frequency that the applied settings imply from the reference frequency, which it receives as a number of MHz. It flags a setting that puts that frequency out of range, and it flags a reference frequency that is itself out of range.

Enabling the loop, waiting for lock and selecting the PLL output as the core clock must happen in that order, and the block enforces it. An enable request is refused while either range flag is set. A connect request is refused until the loop is enabled and lock has been seen. A commit while connected forces the core clock back to the reference. A lock loss while connected does the same and also leaves a sticky status bit. A timeout counter, measured in reference cycles, reports a loop that does not lock within the settling window.

The clock-select output is a registered flag only. The glitch-free multiplexer that acts on it lies outside this block.

Top module: `pll_switch_ctrl`

## Requirements
- R1: After reset, `enabled_o`, `lock_o`, `clk_sel_o` (0 = reference clock), `lock_lost_o` and `lock_tmo_o` are 0, and the applied settings are multiplier code 0 and divider code 0.
- R2: `cfg_wr_i` loads only the staged settings, and the applied settings (`act_mult_m1_o`, `act_div_sel_o`) do not change on it. A `commit_i` pulse copies the staged settings to the applied outputs at the next clock edge.
- R3: The multiplier code holds the multiplier minus 1, giving multipliers 1 to 32. Divider codes 0, 1, 2 and 3 select 2, 4, 8 and 16. `cco_err_o` is 1 exactly when ref_mhz × multiplier × divider lies outside 156 to 320, both ends included, using the applied settings and the present `ref_mhz_i`.
- R4: `ref_err_o` is 1 exactly when `ref_mhz_i` lies outside 10 to 25, both ends included.
- R5: An enable write (`en_wr_i` with `en_val_i`=1) sets `enabled_o` at the next edge only while both `cco_err_o` and `ref_err_o` are 0. Otherwise it is ignored. A write with `en_val_i`=0 clears `enabled_o` and `clk_sel_o`.
- R6: If either range flag is 1 while enabled, `enabled_o` and `clk_sel_o` both clear at the next edge.
- R7: `lock_o` is `pll_lock_i` registered once and gated by `enabled_o` as it stood before that edge.
- R8: A connect write (`conn_wr_i` with `conn_val_i`=1) sets `clk_sel_o` at the next edge only if `enabled_o` and `lock_o` are both 1. Otherwise it is ignored. A write with `conn_val_i`=0 clears `clk_sel_o`.
- R9: A `commit_i` pulse while connected clears `clk_sel_o` at the next edge. `enabled_o` stays set when the new settings are legal.
- R10: If `lock_o` is 0 while `clk_sel_o` is 1, then at the next edge `clk_sel_o` clears and `lock_lost_o` sets. `lock_lost_o` clears only on reset.
- R11: If `lock_o` stays 0, `lock_tmo_o` rises LOCK_TMO_CYC edges after `enabled_o` rises. It stays set after a late lock, and clears at the edge where `enabled_o` falls or where a commit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_mhz_i | input | REF_W | Reference frequency in MHz |
| cfg_wr_i | input | 1 | Write staged settings |
| cfg_mult_m1_i | input | 5 | Multiplier minus 1 |
| cfg_div_sel_i | input | 2 | Divider code (2,4,8,16) |
| commit_i | input | 1 | Apply staged settings |
| en_wr_i | input | 1 | Enable register write |
| en_val_i | input | 1 | Enable value written |
| conn_wr_i | input | 1 | Connect register write |
| conn_val_i | input | 1 | Connect value written |
| pll_lock_i | input | 1 | Raw lock flag from the analog loop |
| act_mult_m1_o | output | 5 | Applied multiplier code |
| act_div_sel_o | output | 2 | Applied divider code |
| cco_err_o | output | 1 | Oscillator frequency out of range |
| ref_err_o | output | 1 | Reference frequency out of range |
| enabled_o | output | 1 | Loop enabled |
| lock_o | output | 1 | Registered, gated lock status |
| clk_sel_o | output | 1 | Core clock select, 1 = PLL output |
| lock_lost_o | output | 1 | Sticky lock loss while connected |
| lock_tmo_o | output | 1 | Lock did not arrive in time |

## Verification
The range flags are combinational on the applied settings and the reference input. They are sampled after the edge that takes a commit, so a flag can be read at most one cycle after its stimulus. Enable, connect, disconnect and the registered lock are due one edge after the write or the lock change. Under a lock loss, the disconnect and the sticky bit come one edge after `lock_o` falls, which makes two edges after `pll_lock_i` drops. The timeout is checked as still low after LOCK_TMO_CYC−1 edges and high after LOCK_TMO_CYC edges. Every sample is taken 1 time unit after a rising edge, and the inputs change at that same point, away from any edge.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

    typedef struct packed {
        logic [4:0] mult_m1;
        logic [1:0] div_sel;
    } pll_cfg_t;

    typedef struct packed {
        pll_cfg_t staged;
        pll_cfg_t active;
        logic     enabled;
        logic     connected;
        logic     lock;
        logic     lost;
    } ctrl_st_t;

    // divider code 0..3 -> 2,4,8,16
    function automatic logic [4:0] div_factor(input logic [1:0] sel);
        return 5'd2 << sel;
    endfunction

endpackage

// File: rtl/pll_range_chk.sv
module pll_range_chk
    import pll_ctrl_pkg::*;
#(
    parameter int REF_W   = 7,
    parameter int CCO_MIN = 156,
    parameter int CCO_MAX = 320,
    parameter int REF_MIN = 10,
    parameter int REF_MAX = 25
) (
    input  logic [REF_W-1:0] ref_mhz,
    input  pll_cfg_t         cfg,
    output logic             cco_ok,
    output logic             ref_ok
);
    localparam int PROD_W = REF_W + 10;

    logic [PROD_W-1:0] ref_ext;
    logic [PROD_W-1:0] mult_ext;
    logic [PROD_W-1:0] div_ext;
    logic [PROD_W-1:0] cco_mhz;

    always_comb begin
        ref_ext  = PROD_W'(ref_mhz);
        mult_ext = PROD_W'(cfg.mult_m1) + PROD_W'(1);
        div_ext  = PROD_W'(div_factor(cfg.div_sel));
        cco_mhz  = ref_ext * mult_ext * div_ext;
        cco_ok   = (cco_mhz >= PROD_W'(CCO_MIN)) && (cco_mhz <= PROD_W'(CCO_MAX));
        ref_ok   = (ref_mhz >= REF_W'(REF_MIN)) && (ref_mhz <= REF_W'(REF_MAX));
    end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          exp_d, exp_q;

    always_comb begin
        cnt_d = cnt_q;
        exp_d = exp_q;
        if (clear) begin
            cnt_d = '0;
            exp_d = 1'b0;
        end else if (!run) begin
            cnt_d = '0;
        end else if (!exp_q) begin
            cnt_d = cnt_q + CW'(1);
            if (cnt_q == CW'(LIMIT - 1)) exp_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    assign expired = exp_q;

endmodule

// File: rtl/pll_switch_ctrl.sv
module pll_switch_ctrl
    import pll_ctrl_pkg::*;
#(
    parameter int REF_W        = 7,
    parameter int LOCK_TMO_CYC = 2500,
    parameter int CCO_MIN      = 156,
    parameter int CCO_MAX      = 320,
    parameter int REF_MIN      = 10,
    parameter int REF_MAX      = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] ref_mhz_i,
    input  logic             cfg_wr_i,
    input  logic [4:0]       cfg_mult_m1_i,
    input  logic [1:0]       cfg_div_sel_i,
    input  logic             commit_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             conn_wr_i,
    input  logic             conn_val_i,
    input  logic             pll_lock_i,
    output logic [4:0]       act_mult_m1_o,
    output logic [1:0]       act_div_sel_o,
    output logic             cco_err_o,
    output logic             ref_err_o,
    output logic             enabled_o,
    output logic             lock_o,
    output logic             clk_sel_o,
    output logic             lock_lost_o,
    output logic             lock_tmo_o
);
    ctrl_st_t st_d, st_q;
    logic     cco_ok, ref_ok, legal;
    logic     tmr_run, tmr_clear;

    pll_range_chk #(
        .REF_W  (REF_W),
        .CCO_MIN(CCO_MIN),
        .CCO_MAX(CCO_MAX),
        .REF_MIN(REF_MIN),
        .REF_MAX(REF_MAX)
    ) u_range (
        .ref_mhz(ref_mhz_i),
        .cfg    (st_q.active),
        .cco_ok (cco_ok),
        .ref_ok (ref_ok)
    );

    assign legal = cco_ok && ref_ok;

    always_comb begin
        st_d = st_q;

        // settings: stage, then apply on commit
        if (cfg_wr_i) begin
            st_d.staged.mult_m1 = cfg_mult_m1_i;
            st_d.staged.div_sel = cfg_div_sel_i;
        end
        if (commit_i) st_d.active = st_q.staged;

        // lock is trusted only while the loop runs
        st_d.lock = pll_lock_i && st_q.enabled;

        // enable: refused or dropped when settings or reference are illegal
        if (en_wr_i) st_d.enabled = en_val_i ? (st_q.enabled || legal) : 1'b0;
        if (!legal)  st_d.enabled = 1'b0;

        // connect: only after enable and lock
        if (conn_wr_i) begin
            if (!conn_val_i)                       st_d.connected = 1'b0;
            else if (st_q.enabled && st_q.lock)    st_d.connected = 1'b1;
        end
        if (st_q.connected && !st_q.lock) begin
            st_d.connected = 1'b0;
            st_d.lost      = 1'b1;
        end
        if (commit_i || !st_d.enabled) st_d.connected = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_run   = st_q.enabled && !st_q.lock;
    assign tmr_clear = !st_d.enabled || commit_i;

    pll_lock_timer #(.LIMIT(LOCK_TMO_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clear  (tmr_clear),
        .expired(lock_tmo_o)
    );

    assign act_mult_m1_o = st_q.active.mult_m1;
    assign act_div_sel_o = st_q.active.div_sel;
    assign cco_err_o     = !cco_ok;
    assign ref_err_o     = !ref_ok;
    assign enabled_o     = st_q.enabled;
    assign lock_o        = st_q.lock;
    assign clk_sel_o     = st_q.connected;
    assign lock_lost_o   = st_q.lost;

endmodule

// File: rtl/pll_switch_ctrl_chk.sv
module pll_switch_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en_wr_i,
    input logic en_val_i,
    input logic conn_wr_i,
    input logic conn_val_i,
    input logic commit_i,
    input logic cco_err_o,
    input logic ref_err_o,
    input logic enabled_o,
    input logic lock_o,
    input logic clk_sel_o,
    input logic lock_lost_o
);
    assert_enable_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled_o) |-> $past(en_wr_i && en_val_i && !cco_err_o && !ref_err_o));

    assert_illegal_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && (cco_err_o || ref_err_o)) |=> (!enabled_o && !clk_sel_o));

    assert_lock_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> $past(enabled_o));

    assert_connect_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel_o) |-> $past(conn_wr_i && conn_val_i && enabled_o && lock_o));

    assert_commit_disconnect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> !clk_sel_o);

    assert_lock_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_o && !lock_o) |=> (!clk_sel_o && lock_lost_o));

    assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_lost_o) |-> lock_lost_o);
endmodule

bind pll_switch_ctrl pll_switch_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr_i    (en_wr_i),
    .en_val_i   (en_val_i),
    .conn_wr_i  (conn_wr_i),
    .conn_val_i (conn_val_i),
    .commit_i   (commit_i),
    .cco_err_o  (cco_err_o),
    .ref_err_o  (ref_err_o),
    .enabled_o  (enabled_o),
    .lock_o     (lock_o),
    .clk_sel_o  (clk_sel_o),
    .lock_lost_o(lock_lost_o)
);

// File: tb/tb_pll_switch_ctrl.sv
module tb_pll_switch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REF_W      = 7;
    localparam int TMO        = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REF_W-1:0] ref_mhz = 7'd20;
    logic             cfg_wr = 1'b0;
    logic [4:0]       mult_m1 = '0;
    logic [1:0]       div_sel = '0;
    logic             commit = 1'b0;
    logic             en_wr = 1'b0, en_val = 1'b0;
    logic             conn_wr = 1'b0, conn_val = 1'b0;
    logic             pll_lock = 1'b0;
    logic [4:0]       act_mult;
    logic [1:0]       act_div;
    logic             cco_err, ref_err, enabled, lock, clk_sel, lost, tmo;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_switch_ctrl #(.REF_W(REF_W), .LOCK_TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .ref_mhz_i(ref_mhz),
        .cfg_wr_i(cfg_wr), .cfg_mult_m1_i(mult_m1), .cfg_div_sel_i(div_sel),
        .commit_i(commit), .en_wr_i(en_wr), .en_val_i(en_val),
        .conn_wr_i(conn_wr), .conn_val_i(conn_val), .pll_lock_i(pll_lock),
        .act_mult_m1_o(act_mult), .act_div_sel_o(act_div),
        .cco_err_o(cco_err), .ref_err_o(ref_err), .enabled_o(enabled),
        .lock_o(lock), .clk_sel_o(clk_sel), .lock_lost_o(lost), .lock_tmo_o(tmo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit cco_legal(input int r, input int m1, input int d);
        int f;
        f = r * (m1 + 1) * (2 << d);
        return (f >= 156) && (f <= 320);
    endfunction

    function automatic bit ref_legal(input int r);
        return (r >= 10) && (r <= 25);
    endfunction

    task automatic apply_cfg(input int r, input int m1, input int d);
        ref_mhz = REF_W'(r);
        mult_m1 = 5'(m1);
        div_sel = 2'(d);
        cfg_wr  = 1'b1;
        tick();
        cfg_wr  = 1'b0;
        commit  = 1'b1;
        tick();
        commit  = 1'b0;
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_val = v;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic write_conn(input logic v);
        conn_wr = 1'b1; conn_val = v;
        tick();
        conn_wr = 1'b0;
    endtask

    // range flags and enable acceptance for one setting
    task automatic try_point(input string tag, input int r, input int m1, input int d);
        bit ok;
        apply_cfg(r, m1, d);
        ok = cco_legal(r, m1, d) && ref_legal(r);
        chk({tag, " R3 cco_err"}, cco_err, !cco_legal(r, m1, d));
        chk({tag, " R4 ref_err"}, ref_err, !ref_legal(r));
        write_en(1'b1);
        chk({tag, " R5 enable"}, enabled, ok);
        write_en(1'b0);
        chk({tag, " R5 disable"}, enabled, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1 reset state
        chk("R1 enabled", enabled, 0);
        chk("R1 lock", lock, 0);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 lock_lost", lost, 0);
        chk("R1 lock_tmo", tmo, 0);
        chk("R1 mult", act_mult, 0);
        chk("R1 div", act_div, 0);

        // R2 staging vs commit
        mult_m1 = 5'd7; div_sel = 2'd0; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
        chk("R2 staged only mult", act_mult, 0);
        commit = 1'b1;
        tick();
        commit = 1'b0;
        chk("R2 commit mult", act_mult, 7);
        chk("R2 commit div", act_div, 0);

        // R3/R4/R5 boundary points
        try_point("156 edge", 13, 5, 0);
        try_point("154 low", 11, 6, 0);
        try_point("320 edge", 20, 7, 0);
        try_point("322 high", 23, 6, 0);
        try_point("ref 10", 10, 7, 0);
        try_point("ref 9", 9, 8, 0);
        try_point("ref 25", 25, 3, 0);
        try_point("ref 26", 26, 2, 0);
        try_point("div16", 10, 0, 3);
        try_point("div8", 10, 1, 2);
        try_point("div16 320", 20, 0, 3);
        try_point("div16 640", 20, 1, 3);
        try_point("mult32", 10, 31, 0);

        // R8 connect before lock ignored, R7 lock
        apply_cfg(20, 3, 1);
        write_en(1'b1);
        chk("R5 legal enable", enabled, 1);
        write_conn(1'b1);
        chk("R8 connect before lock ignored", clk_sel, 0);
        pll_lock = 1'b1;
        tick();
        chk("R7 lock registered", lock, 1);
        write_conn(1'b1);
        chk("R8 connect after lock", clk_sel, 1);
        write_conn(1'b0);
        chk("R8 disconnect write", clk_sel, 0);
        write_conn(1'b1);

        // R9 commit while connected
        commit = 1'b1;
        tick();
        commit = 1'b0;
        chk("R9 commit disconnects", clk_sel, 0);
        chk("R9 enable kept", enabled, 1);

        // R6 reference goes out of range while connected
        write_conn(1'b1);
        chk("R8 reconnect", clk_sel, 1);
        ref_mhz = 7'd30;
        tick();
        chk("R6 enable dropped", enabled, 0);
        chk("R6 clk_sel dropped", clk_sel, 0);
        tick();
        chk("R7 lock gated by enable", lock, 0);
        chk("R10 no loss on drop", lost, 0);
        ref_mhz = 7'd20;
        write_en(1'b1);
        chk("R5 enable again", enabled, 1);

        // R8 disable clears connect
        tick();
        write_conn(1'b1);
        write_en(1'b0);
        chk("R5 disable clears clk_sel", clk_sel, 0);

        // R10 lock loss
        write_en(1'b1);
        tick();
        write_conn(1'b1);
        chk("R10 connected", clk_sel, 1);
        pll_lock = 1'b0;
        tick();
        chk("R10 lock falls", lock, 0);
        chk("R10 still selected one edge", clk_sel, 1);
        tick();
        chk("R10 bypass", clk_sel, 0);
        chk("R10 sticky set", lost, 1);
        pll_lock = 1'b1;
        tick();
        tick();
        chk("R10 sticky held", lost, 1);

        // R11 timeout
        write_en(1'b0);
        pll_lock = 1'b0;
        tick();
        write_en(1'b1);
        for (int i = 0; i < TMO - 1; i++) tick();
        chk("R11 not yet", tmo, 0);
        tick();
        chk("R11 timeout", tmo, 1);
        pll_lock = 1'b1;
        tick();
        tick();
        chk("R11 held after late lock", tmo, 1);
        write_en(1'b0);
        chk("R11 cleared by disable", tmo, 0);
        pll_lock = 1'b0;

        do_reset();
        chk("R1 lock_lost after reset", lost, 0);

        // random settings
        for (int n = 0; n < 200; n++) begin
            int r, m, d;
            r = 5 + int'($urandom % 36);
            m = int'($urandom % 32);
            d = int'($urandom % 4);
            try_point("random", r, m, d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule